// File: doc/BRIEF.md
# Serial Offset Register Loader

This block fills the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against. It takes one data bit per write-clock edge from a serial input. A bit is taken only on an edge where both the load-mode input and the serial-enable input are high. The stream is split into two halves of equal length. The first half becomes the almost-empty offset and the second half becomes the almost-full offset. Each half is sent least significant bit first.

The offset width is `OFS_MSB + 1`, where `OFS_MSB` is 15 or 16. A full load therefore takes 32 or 34 accepted bits. Incoming bits collect in a private staging word. A visible offset changes only on the edge that accepts its final bit, and then all of its bits change together. The flag logic never sees a half-written threshold.

After the last almost-full bit, the next accepted bit starts a new almost-empty load. Reset puts both offsets back to their parameter defaults and sends the bit position back to the start of the almost-empty half.

Top module: `offset_serial_loader`

## Requirements
- R1: While reset is asserted, and after it is released, `ae_offset` equals `AE_RESET` and `af_offset` equals `AF_RESET`. The next accepted bit is bit 0 of the almost-empty offset, even if reset arrives partway through a transfer.
- R2: A bit on `ser_bit` is accepted on a rising edge of `clk` only when `load_mode` is 1 and `ser_en` is 1.
- R3: The first `OFS_MSB+1` accepted bits form the almost-empty offset, with the first accepted bit placed at bit 0.
- R4: The next `OFS_MSB+1` accepted bits form the almost-full offset, with the first of them placed at bit 0.
- R5: `ae_offset` holds its value until the edge that accepts the final almost-empty bit. On that edge it takes all the new bits at once.
- R6: `af_offset` holds its value until the edge that accepts the final almost-full bit. In particular it does not change while an almost-empty load is in progress.
- R7: An edge with `ser_en` at 0 accepts no bit and keeps the bit position, so the transfer resumes where it stopped.
- R8: An edge with `load_mode` at 0 and `ser_en` at 1 accepts no bit and keeps the bit position.
- R9: After the final almost-full bit, the next accepted bit is bit 0 of a new almost-empty offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock; bits are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_mode | input | 1 | 1 selects serial load mode |
| ser_en | input | 1 | 1 accepts the bit on `ser_bit` |
| ser_bit | input | 1 | Serial offset data |
| ae_offset | output | OFS_MSB+1 | Almost-empty offset seen by the flag logic |
| af_offset | output | OFS_MSB+1 | Almost-full offset seen by the flag logic |

## Verification
The assertions assume the serial inputs are stable around each rising edge of `clk`. They also assume that `load_mode` is released only to suspend a transfer, never to end it implicitly. The assertions then check only what happens to the bit position and to the visible offsets from one edge to the next.

The bench changes every input on the falling edge. This keeps set-up margins wide and gives each rising edge one well-defined bit. The bench also drops `load_mode` and `ser_en` in the middle of an offset, so the hold and resume paths are exercised with live data on `ser_bit`.

// File: rtl/sol_pkg.sv
package sol_pkg;

   // Which offset the current bit position belongs to
   typedef enum logic {
      TGT_EMPTY = 1'b0,
      TGT_FULL  = 1'b1
   } target_e;

endpackage

// File: rtl/offset_bit_counter.sv
module offset_bit_counter
   import sol_pkg::*;
#(
   parameter int W = 16,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [IW-1:0] idx,
   output target_e       target,
   output logic          last_bit
);

   localparam logic [IW-1:0] IDX_TOP = IW'(W - 1);

   assign last_bit = (idx == IDX_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= '0;
         target <= TGT_EMPTY;
      end else if (step) begin
         if (last_bit) begin
            idx    <= '0;
            target <= (target == TGT_EMPTY) ? TGT_FULL : TGT_EMPTY;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   // The bit index never leaves the offset width
   assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= IDX_TOP);

   // An edge that accepts no bit keeps the position (R7, R8)
   assert_pos_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(idx) && $stable(target)));

   // The final almost-full bit sends the position back to the start of the empty half
   assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last_bit && target == TGT_FULL) |=> (idx == '0 && target == TGT_EMPTY));

   // The final almost-empty bit moves the position into the full half
   assert_half_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last_bit && target == TGT_EMPTY) |=> (idx == '0 && target == TGT_FULL));

endmodule

// File: rtl/offset_stage_shift.sv
module offset_stage_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         bit_in,
   output logic [W-1:0] word_next
);

   logic [W-1:0] stage;

   // The newest bit enters at the top; after W steps the first bit reaches bit 0
   assign word_next = {bit_in, stage[W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stage <= '0;
      else if (step) stage <= word_next;
   end

endmodule

// File: rtl/offset_stage_index.sv
module offset_stage_index #(
   parameter int W = 16,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          bit_in,
   input  logic [IW-1:0] idx,
   output logic [W-1:0]  word_next
);

   logic [W-1:0] stage;

   // Each bit is written straight into its own position
   always_comb begin
      word_next      = stage;
      word_next[idx] = bit_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stage <= '0;
      else if (step) stage <= word_next;
   end

endmodule

// File: rtl/offset_hold_reg.sv
module offset_hold_reg #(
   parameter int          W         = 16,
   parameter int unsigned RESET_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   localparam logic [W-1:0] RST_Q = W'(RESET_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_Q;
      else if (load) q <= d;
   end

endmodule

// File: rtl/offset_serial_loader.sv
module offset_serial_loader
   import sol_pkg::*;
#(
   parameter int          OFS_MSB     = 15,
   parameter int unsigned AE_RESET    = 7,
   parameter int unsigned AF_RESET    = 63,
   parameter bit          STAGE_SHIFT = 1'b1,
   localparam int         W           = OFS_MSB + 1,
   localparam int         IW          = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_mode,
   input  logic         ser_en,
   input  logic         ser_bit,
   output logic [W-1:0] ae_offset,
   output logic [W-1:0] af_offset
);

   // Elaboration-time parameter checks
   if (OFS_MSB != 15 && OFS_MSB != 16) begin : g_bad_msb
      $error("offset_serial_loader: OFS_MSB must be 15 or 16");
   end
   if (longint'(AE_RESET) >= (longint'(1) << W) ||
       longint'(AF_RESET) >= (longint'(1) << W)) begin : g_bad_reset
      $error("offset_serial_loader: reset offsets do not fit the offset width");
   end

   logic          step;
   logic [IW-1:0] idx;
   target_e       target;
   logic          last_bit;
   logic [W-1:0]  word_next;
   logic          commit_ae;
   logic          commit_af;

   // A bit is accepted only when both gating inputs are high
   assign step = load_mode & ser_en;

   offset_bit_counter #(.W(W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .idx      (idx),
      .target   (target),
      .last_bit (last_bit)
   );

   if (STAGE_SHIFT) begin : g_stage_shift
      offset_stage_shift #(.W(W)) u_stage (
         .clk       (clk),
         .rst_n     (rst_n),
         .step      (step),
         .bit_in    (ser_bit),
         .word_next (word_next)
      );
   end else begin : g_stage_index
      offset_stage_index #(.W(W)) u_stage (
         .clk       (clk),
         .rst_n     (rst_n),
         .step      (step),
         .bit_in    (ser_bit),
         .idx       (idx),
         .word_next (word_next)
      );
   end

   assign commit_ae = step && last_bit && (target == TGT_EMPTY);
   assign commit_af = step && last_bit && (target == TGT_FULL);

   offset_hold_reg #(.W(W), .RESET_VAL(AE_RESET)) u_ae_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (commit_ae),
      .d     (word_next),
      .q     (ae_offset)
   );

   offset_hold_reg #(.W(W), .RESET_VAL(AF_RESET)) u_af_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (commit_af),
      .d     (word_next),
      .q     (af_offset)
   );

   // The visible almost-empty offset moves only on its final-bit edge
   assert_ae_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_mode && ser_en && last_bit && target == TGT_EMPTY) |=> $stable(ae_offset));

   // The visible almost-full offset moves only on its final-bit edge
   assert_af_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_mode && ser_en && last_bit && target == TGT_FULL) |=> $stable(af_offset));

   // With load mode off, neither offset can change
   assert_ld_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load_mode |=> ($stable(ae_offset) && $stable(af_offset)));

   // The two offsets never change on the same edge
   assert_single_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_ae && commit_af));

endmodule

// File: tb/offset_serial_loader_bench.sv
`timescale 1ns/1ps
module offset_serial_loader_bench;

   localparam int          MSB_B = 15;
   localparam int          W_B   = MSB_B + 1;
   localparam int unsigned AE_RV = 7;
   localparam int unsigned AF_RV = 63;
   localparam int          NVEC  = 6;

   // Each entry: upper half = almost-full value, lower half = almost-empty value
   localparam logic [2*W_B-1:0] VEC [NVEC] = '{
      32'hFFFF_0000,
      32'h0000_FFFF,
      32'hA5A5_5A5A,
      32'h8001_0001,
      32'h1234_C3F0,
      32'h7FFE_8000
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           load_mode = 1'b0;
   logic           ser_en = 1'b0;
   logic           ser_bit = 1'b0;
   logic [W_B-1:0] ae_offset;
   logic [W_B-1:0] af_offset;

   int n_checks = 0;
   int n_errors = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   offset_serial_loader #(
      .OFS_MSB (MSB_B),
      .AE_RESET(AE_RV),
      .AF_RESET(AF_RV)
   ) u_offset_serial_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_mode(load_mode),
      .ser_en   (ser_en),
      .ser_bit  (ser_bit),
      .ae_offset(ae_offset),
      .af_offset(af_offset)
   );

   task automatic check(input string tag, input logic [W_B-1:0] act, input logic [W_B-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive on a falling edge, then wait for the next falling edge
   task automatic push(input logic b, input logic en, input logic ld);
      ser_bit   = b;
      ser_en    = en;
      load_mode = ld;
      @(negedge clk);
   endtask

   task automatic send_word(input logic [W_B-1:0] w);
      for (int i = 0; i < W_B; i++) push(w[i], 1'b1, 1'b1);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 ae reset", ae_offset, W_B'(AE_RV));
      check("R1 af reset", af_offset, W_B'(AF_RV));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ae after release", ae_offset, W_B'(AE_RV));

      // Table walk: R3 and R4, each entry starting after the wrap (R9)
      for (int v = 0; v < NVEC; v++) begin
         send_word(VEC[v][W_B-1:0]);
         send_word(VEC[v][2*W_B-1:W_B]);
         check($sformatf("R3 vec%0d ae", v), ae_offset, VEC[v][W_B-1:0]);
         check($sformatf("R4 vec%0d af", v), af_offset, VEC[v][2*W_B-1:W_B]);
      end

      // R5 / R6: ae held until its final bit; af untouched during the ae reload
      for (int i = 0; i < W_B - 1; i++) push(1'b1 ^ i[0], 1'b1, 1'b1);
      check("R5 ae held before final bit", ae_offset, VEC[NVEC-1][W_B-1:0]);
      push(1'b1, 1'b1, 1'b1);
      check("R5 ae updated on final bit", ae_offset, 16'hD555);
      check("R6 af unchanged by ae load", af_offset, VEC[NVEC-1][2*W_B-1:W_B]);
      for (int i = 0; i < W_B - 1; i++) push(1'b0, 1'b1, 1'b1);
      check("R6 af held before final bit", af_offset, VEC[NVEC-1][2*W_B-1:W_B]);
      push(1'b1, 1'b1, 1'b1);
      check("R6 af updated on final bit", af_offset, 16'h8000);

      // R7: pause with ser_en low while ser_bit toggles (R2: bits not taken)
      for (int i = 0; i < 8; i++) push(1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 5; i++) push(i[0], 1'b0, 1'b1);
      check("R7 ae stable during pause", ae_offset, 16'hD555);
      for (int i = 0; i < 8; i++) push(1'b0, 1'b1, 1'b1);
      check("R7 ae resumes at position", ae_offset, 16'h00FF);

      // R8: load_mode low with ser_en high ignores bits
      for (int i = 0; i < 4; i++) push(1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 6; i++) push(1'b1, 1'b1, 1'b0);
      check("R8 af stable with load off", af_offset, 16'h8000);
      for (int i = 0; i < 12; i++) push(1'b0, 1'b1, 1'b1);
      check("R8 af position kept", af_offset, 16'h000F);
      check("R2 ae untouched by af load", ae_offset, 16'h00FF);

      // R9: the next bits after af reload the ae offset
      send_word(16'h3C69);
      check("R9 wrap into ae", ae_offset, 16'h3C69);
      check("R9 af not touched", af_offset, 16'h000F);

      // R1: reset partway through a transfer
      for (int i = 0; i < 5; i++) push(1'b1, 1'b1, 1'b1);
      rst_n = 1'b0;
      load_mode = 1'b0;
      ser_en = 1'b0;
      @(negedge clk);
      check("R1 ae mid reset", ae_offset, W_B'(AE_RV));
      check("R1 af mid reset", af_offset, W_B'(AF_RV));
      rst_n = 1'b1;
      @(negedge clk);
      send_word(16'hBEEF);
      check("R1 position cleared", ae_offset, 16'hBEEF);
      check("R1 af kept default", af_offset, W_B'(AF_RV));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule